// File: doc/BRIEF.md
# Phase-Modulated Sine/Cosine Oscillator Core

This block is the oscillator core of a numerically controlled oscillator. A 32-bit phase accumulator advances on every clock by the active frequency increment and wraps modulo 2^32. A 12-bit phase-offset word is added to the accumulator's top bits, which gives phase modulation. The sum, cut to 13 bits of phase, addresses a quarter-wave sine table. The block outputs 12-bit offset-binary sine and cosine amplitudes.

The frequency increment and the phase-offset word each have their own load pulse. A new increment travels through a fixed-length pipeline and first reaches the outputs 19 rising edges after its load. A new phase offset reaches the outputs two edges after its load. After reset, both outputs stay at the zero-phase code 801H until the first loaded value reaches them.

Top module: `nco_pm_core`

## Requirements
- R1: The accumulator adds the active increment on every rising edge and wraps modulo 2^32. After the active increment first becomes `I` from a zero accumulator, the accumulator value seen at the outputs `m` edges later is `(m+1)*I mod 2^32`.
- R2: The 12-bit phase offset `W` is added to the top 12 accumulator bits. The 13-bit table phase is `P = (acc[31:19] + 2*W) mod 8192`. An offset of 800H shifts the output by 180 degrees.
- R3: For a phase `P`, the sine code is `2048 + round(2047*sin(2*pi*(P+0.5)/8192))` when that sine is positive, and `2047 - round(2047*|sin|)` otherwise (within one LSB). Codes for `P < 4096` have bit 11 set, and codes for the other half have bit 11 clear. The cosine uses `P + 2048`.
- R4: During reset, both outputs are 801H. After reset, they stay at 801H until the first frequency load or phase load reaches the output stage.
- R5: If `freq_load` is sampled high at edge E0, the output sampled after edge E0+18 still reflects the previous accumulator value. The output sampled after edge E0+19 reflects the new increment.
- R6: An increment of 80000000H (half the clock rate) makes the sine alternate between the two phase halves on successive clocks.
- R7: If `phase_load` is sampled high at edge E0, the new offset is visible after edge E0+2. Changes on `phase_word` while `phase_load` is low have no effect.
- R8: Changes on `freq_word` while `freq_load` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 32 | Frequency increment, captured when freq_load is high |
| freq_load | input | 1 | Load pulse for freq_word |
| phase_word | input | 12 | Phase offset, captured when phase_load is high |
| phase_load | input | 1 | Load pulse for phase_word |
| sine_o | output | 12 | Offset-binary sine amplitude |
| cosine_o | output | 12 | Offset-binary cosine amplitude |

## Verification
The bench builds the core with its default parameters: a 32-bit accumulator, a 12-bit offset, 13-bit table phase, 12-bit amplitude and a 19-edge frequency latency. With these values the full 2048-entry quarter table is exercised, and so are the 32-bit wrap of a decrementing accumulator and the half-rate increment. The bench can also place samples exactly on either side of the 19-edge boundary. Expected amplitudes come from a real-valued sine evaluated over the whole circle, with no quadrant folding, so any mistake in the RTL's mirroring or sign logic shows up as a mismatch.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // quadrant of the table phase, taken from its two most significant bits
  typedef enum logic [1:0] {
    QD_RISE  = 2'd0,
    QD_FALL  = 2'd1,
    QD_DIP   = 2'd2,
    QD_CLIMB = 2'd3
  } quad_e;
endpackage

// File: rtl/nco_load_delay.sv
// Fixed-depth shift line carrying a load strobe and its payload.
module nco_load_delay #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic         v_q [DEPTH];
  logic [W-1:0] d_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) v_q[0] <= 1'b0;
    else     v_q[0] <= in_v;
    d_q[0] <= in_d;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) v_q[s] <= 1'b0;
      else     v_q[s] <= v_q[s-1];
      d_q[s] <= d_q[s-1];
    end
  end

  assign out_v = v_q[DEPTH-1];
  assign out_d = d_q[DEPTH-1];
endmodule

// File: rtl/nco_phase_acc.sv
// Active increment register and wrapping phase accumulator.
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_v,
  input  logic [ACC_W-1:0] upd_incr,
  output logic [ACC_W-1:0] acc_q,
  output logic             took_q
);
  logic [ACC_W-1:0] active_q;

  function automatic logic [ACC_W-1:0] step_acc(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] inc);
    return a + inc;  // modulo 2^ACC_W
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
      acc_q    <= '0;
      took_q   <= 1'b0;
    end else begin
      if (upd_v) active_q <= upd_incr;
      took_q <= upd_v;
      acc_q  <= step_acc(acc_q, active_q);
    end
  end

  // R8
  active_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_v |=> $stable(active_q));
  // R1
  acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q == '0) |=> $stable(acc_q));
endmodule

// File: rtl/nco_quarter_lut.sv
// Quarter-wave sine table with quadrant folding and half-circle sign.
module nco_quarter_lut #(
  parameter int PH_RES = 13,
  parameter int AMP_W  = 12
) (
  input  logic [PH_RES-1:0] phase,
  output logic [AMP_W-1:0]  amp
);
  import nco_pkg::*;

  localparam int  QAW    = PH_RES - 2;
  localparam int  QD     = 1 << QAW;
  localparam int  MAG_W  = AMP_W - 1;
  localparam real MAGMAX = real'((1 << MAG_W) - 1);
  localparam real PI     = 3.14159265358979;
  localparam real STEPS  = real'(1 << PH_RES);

  logic [MAG_W-1:0] qtab [QD];

  for (genvar i = 0; i < QD; i++) begin : g_tab
    localparam real ANG = 2.0 * PI * (real'(i) + 0.5) / STEPS;
    localparam int  VAL = $rtoi($floor(MAGMAX * $sin(ANG) + 0.5));
    assign qtab[i] = MAG_W'(VAL);
  end

  function automatic logic [QAW-1:0] fold(input quad_e q, input logic [QAW-1:0] lo);
    return (q == QD_FALL || q == QD_CLIMB) ? ~lo : lo;
  endfunction

  function automatic logic [AMP_W-1:0] signed_code(input logic neg, input logic [MAG_W-1:0] m);
    return neg ? {1'b0, ~m} : {1'b1, m};
  endfunction

  quad_e            quad;
  logic [MAG_W-1:0] mag;

  always_comb begin
    quad = quad_e'(phase[PH_RES-1 -: 2]);
    mag  = qtab[fold(quad, phase[QAW-1:0])];
    amp  = signed_code(phase[PH_RES-1], mag);
  end
endmodule

// File: rtl/nco_pm_core.sv
// Phase-modulated oscillator core: load pipeline, accumulator, offset, tables.
module nco_pm_core #(
  parameter int ACC_W    = 32,
  parameter int POFF_W   = 12,
  parameter int PH_RES   = 13,
  parameter int AMP_W    = 12,
  parameter int FREQ_LAT = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  freq_word,
  input  logic              freq_load,
  input  logic [POFF_W-1:0] phase_word,
  input  logic              phase_load,
  output logic [AMP_W-1:0]  sine_o,
  output logic [AMP_W-1:0]  cosine_o
);
  localparam int                DLY       = FREQ_LAT - 3;
  localparam logic [AMP_W-1:0]  IDLE_CODE = {1'b1, {(AMP_W-2){1'b0}}, 1'b1};
  localparam logic [PH_RES-1:0] QTR_TURN  = PH_RES'(1) << (PH_RES - 2);

  logic              dl_v;
  logic [ACC_W-1:0]  dl_incr;
  logic [ACC_W-1:0]  acc_q;
  logic              took_q;
  logic [POFF_W-1:0] off_q;
  logic              run0_q, run1_q;
  logic [PH_RES-1:0] phase_q;
  logic [AMP_W-1:0]  sin_amp, cos_amp;

  function automatic logic [PH_RES-1:0] mod_phase(input logic [ACC_W-1:0]  a,
                                                  input logic [POFF_W-1:0] w);
    return a[ACC_W-1 -: PH_RES] + {w, {(PH_RES-POFF_W){1'b0}}};
  endfunction

  nco_load_delay #(.W(ACC_W), .DEPTH(DLY)) u_dly (
    .clk(clk), .rst(rst), .in_v(freq_load), .in_d(freq_word),
    .out_v(dl_v), .out_d(dl_incr)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .upd_v(dl_v), .upd_incr(dl_incr),
    .acc_q(acc_q), .took_q(took_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q   <= '0;
      run0_q  <= 1'b0;
      run1_q  <= 1'b0;
      phase_q <= '0;
    end else begin
      if (phase_load) off_q <= phase_word;
      if (phase_load || took_q) run0_q <= 1'b1;
      run1_q  <= run0_q;
      phase_q <= mod_phase(acc_q, off_q);
    end
  end

  nco_quarter_lut #(.PH_RES(PH_RES), .AMP_W(AMP_W)) u_sin (
    .phase(phase_q), .amp(sin_amp)
  );
  nco_quarter_lut #(.PH_RES(PH_RES), .AMP_W(AMP_W)) u_cos (
    .phase(phase_q + QTR_TURN), .amp(cos_amp)
  );

  always_ff @(posedge clk) begin
    if (rst || !run1_q) begin
      sine_o   <= IDLE_CODE;
      cosine_o <= IDLE_CODE;
    end else begin
      sine_o   <= sin_amp;
      cosine_o <= cos_amp;
    end
  end

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run1_q |=> (sine_o == IDLE_CODE && cosine_o == IDLE_CODE));
  // R3
  half_sign_chk: assert property (@(posedge clk) disable iff (rst)
    run1_q |=> (sine_o[AMP_W-1] == !$past(phase_q[PH_RES-1])));
  // R7
  offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !phase_load |=> $stable(off_q));
endmodule

// File: tb/sim_nco_pm_core.sv
module sim_nco_pm_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] freq_word = '0;
  logic        freq_load = 1'b0;
  logic [11:0] phase_word = '0;
  logic        phase_load = 1'b0;
  logic [11:0] sine_o, cosine_o;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  nco_pm_core u0 (
    .clk(clk), .rst(rst), .freq_word(freq_word), .freq_load(freq_load),
    .phase_word(phase_word), .phase_load(phase_load),
    .sine_o(sine_o), .cosine_o(cosine_o)
  );

  // {increment, phase offset}
  localparam logic [43:0] VEC [6] = '{
    {32'h0010_0000, 12'h000},
    {32'h8000_0000, 12'h000},
    {32'hFFFF_FFFF, 12'h000},
    {32'h1234_5678, 12'h800},
    {32'h0400_0000, 12'h3FF},
    {32'hC000_0000, 12'h400}
  };

  function automatic int amp_of(input int p);
    real s;
    s = $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 8192.0);
    if (s >= 0.0) return 2048 + $rtoi($floor(2047.0 * s + 0.5));
    else          return 2047 - $rtoi($floor(-2047.0 * s + 0.5));
  endfunction

  function automatic int ph_of(input longint acc, input int off);
    return int'(((acc >> 19) + longint'(off) * 2) & 8191);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [11:0] act, input int exp, input bit tol);
    int d;
    n_run++;
    d = int'(act) - exp;
    if (d < 0) d = -d;
    if (d > (tol ? 1 : 0)) begin
      n_bad++;
      $display("FAIL %s: actual %03h expected %03h", tag, act, exp[11:0]);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; freq_load = 1'b0; phase_load = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic chk_phase(input string tag, input int p);
    chk(tag, sine_o, amp_of(p), 1'b1);
    chk(tag, cosine_o, amp_of((p + 2048) & 8191), 1'b1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    // R4: reset state
    rst = 1'b1;
    step(); step();
    chk("R4 reset sine", sine_o, 12'h801, 1'b0);
    chk("R4 reset cosine", cosine_o, 12'h801, 1'b0);
    rst = 1'b0;

    // R7 R8: inputs moving without load pulses leave outputs idle
    freq_word = 32'h4000_0000; phase_word = 12'h555;
    for (int k = 0; k < 30; k++) step();
    chk("R8 freq ignored", sine_o, 12'h801, 1'b0);
    chk("R7 phase ignored", cosine_o, 12'h801, 1'b0);

    // Vector table: both loads at edge E0
    for (int v = 0; v < 6; v++) begin
      longint inc;
      int     off;
      inc = longint'(VEC[v][43:12]);
      off = int'(VEC[v][11:0]);
      do_reset();
      freq_word = VEC[v][43:12]; phase_word = VEC[v][11:0];
      freq_load = 1'b1; phase_load = 1'b1;
      step();  // E0
      freq_load = 1'b0; phase_load = 1'b0;
      step(); step();
      chk_phase("R7 R2 offset after two edges", ph_of(0, off));
      for (int k = 3; k <= 18; k++) step();
      chk_phase("R5 old phase at E0+18", ph_of(0, off));
      for (int m = 0; m <= 40; m++) begin
        step();
        if (m <= 2 || m == 40)
          chk_phase("R1 R3 R5 accumulated phase",
                    ph_of((longint'(m + 1) * inc) & 64'hFFFF_FFFF, off));
        if (v == 1 && m == 1)
          chk("R6 half-rate alternation", sine_o, 12'h801, 1'b1);
        if (v == 1 && m == 0)
          chk("R6 half-rate alternation", sine_o, 12'h7FE, 1'b1);
      end
      if (v == 4) begin
        // R8: running, new freq_word without load has no effect
        freq_word = 32'h0123_4567;
        for (int m = 41; m <= 60; m++) step();
        chk_phase("R8 running freq ignored",
                  ph_of((longint'(61) * inc) & 64'hFFFF_FFFF, off));
      end
    end

    // R4 R5: frequency-only load, outputs held until E0+19
    do_reset();
    freq_word = 32'h4000_0000; freq_load = 1'b1;
    step();
    freq_load = 1'b0;
    for (int k = 1; k <= 18; k++) step();
    chk("R4 held sine at E0+18", sine_o, 12'h801, 1'b0);
    chk("R4 held cosine at E0+18", cosine_o, 12'h801, 1'b0);
    step();
    chk("R5 sine at E0+19", sine_o, 12'hFFF, 1'b1);
    chk("R5 cosine at E0+19", cosine_o, 12'h7FE, 1'b1);

    // R4: reset mid-run returns to idle and stays there
    rst = 1'b1;
    step();
    chk("R4 mid-run reset", sine_o, 12'h801, 1'b0);
    rst = 1'b0;
    for (int k = 0; k < 10; k++) step();
    chk("R4 idle after reset", sine_o, 12'h801, 1'b0);
    chk("R4 idle cosine after reset", cosine_o, 12'h801, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule